// File: doc/BRIEF.md
# ADC Output Test Pattern Generator

This block sits at the end of a converter's output path and decides which 14-bit word reaches the output bus. When testing is off, the normal converted sample passes through. When one of seven test modes is selected, a generated word takes the place of the sample. The generated words are constants, two alternating patterns, or one of two pseudo-random sequences.

A 3-bit mode input chooses the source. A sample-clock enable marks the cycles in which a new word is produced. Two reset inputs, one for each pseudo-random generator, return that generator to its seed. The output word is registered: a word selected in an enabled cycle appears on the bus one clock later.

Top module: `adc_tpg`

## Requirements
- R1: After the asynchronous reset `rst_ni` is asserted, `data_o` reads 0x0000. Both generators are loaded with all ones, and the pattern phase is cleared.
- R2: Mode 0 (`mode_i`=000) passes data through. In a cycle with `sample_en_i` high, `data_i` is captured and appears on `data_o` after the next rising edge.
- R3: Modes 1, 2 and 3 produce constant offset-binary words. Mode 1 gives midscale 0x2000, mode 2 gives positive full scale 0x3FFF, and mode 3 gives negative full scale 0x0000.
- R4: Mode 4 produces a checkerboard. The first enabled word after entering the mode is 0x2AAA, and each later enabled word alternates between 0x1555 and 0x2AAA.
- R5: Mode 7 produces a word toggle. The first enabled word after entering the mode is 0x3FFF, and each later enabled word alternates between 0x0000 and 0x3FFF.
- R6: Mode 6 produces the PN9 sequence. It uses a 14-bit history register `h` seeded to all ones. Each word output is the current `h`, and after each enabled step `h` becomes `{h[12:0], h[8]^h[4]}`, which is x^9+x^5+1.
- R7: Mode 5 produces the PN23 sequence. It uses a 23-bit register `s` seeded to all ones. Each word output is `s[22:9]`, and after each enabled step `s` becomes `{s[21:0], s[22]^s[17]}`, which is x^23+x^18+1.
- R8: While `pn9_rst_i` or `pn23_rst_i` is high, the matching generator is held at its seed in any mode. The first word it outputs after the reset is released is 0x3FFF.
- R9: A generator steps only in enabled cycles while its own mode is selected. After a detour through other modes, its sequence resumes where it stopped.
- R10: In a cycle with `sample_en_i` low, `data_o` holds its value and neither the generators nor the pattern phase advance.
- R11: Any mode other than 4 or 7 clears the pattern phase. Re-entering mode 4 or mode 7 therefore restarts at its first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_en_i | input | 1 | Sample-clock enable |
| mode_i | input | 3 | Output source select (0 = normal data) |
| pn23_rst_i | input | 1 | Hold the PN23 generator at its seed |
| pn9_rst_i | input | 1 | Hold the PN9 generator at its seed |
| data_i | input | 14 | Normal converted sample |
| data_o | output | 14 | Registered output word |

## Verification
Every result of this block becomes visible exactly one rising edge after the enabled cycle that selected it. Generator and phase state likewise take effect on the following edge.

The bench applies all inputs just after a falling edge and steps a requirement-level model of the registers in the same task. It compares `data_o` at the next falling edge, so each comparison falls exactly one register stage after its stimulus. Cycles with the enable low are interleaved to confirm that the output holds its value over the whole idle span.

// File: rtl/adc_tpg_pkg.sv
package adc_tpg_pkg;
  typedef enum logic [2:0] {
    MODE_OFF    = 3'd0,
    MODE_MID    = 3'd1,
    MODE_PFS    = 3'd2,
    MODE_NFS    = 3'd3,
    MODE_CHECK  = 3'd4,
    MODE_PN23   = 3'd5,
    MODE_PN9    = 3'd6,
    MODE_TOGGLE = 3'd7
  } tpg_mode_e;
endpackage

// File: rtl/tpg_lfsr.sv
// Fibonacci LFSR held as a shift history; REG_W >= OUT_W so short polynomials still fill the word.
module tpg_lfsr #(
  parameter int POLY_W = 9,
  parameter int TAP    = 5,
  parameter int OUT_W  = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seed_i,
  input  logic             step_i,
  output logic [OUT_W-1:0] word_o
);
  localparam int REG_W = (POLY_W > OUT_W) ? POLY_W : OUT_W;

  logic [REG_W-1:0] state_q;
  logic             fb;

  assign fb     = state_q[POLY_W-1] ^ state_q[TAP-1];
  assign word_o = state_q[REG_W-1 -: OUT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= '1;
    else if (seed_i)  state_q <= '1;
    else if (step_i)  state_q <= {state_q[REG_W-2:0], fb};
  end
endmodule

// File: rtl/tpg_phase.sv
module tpg_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  output logic phase_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      phase_o <= 1'b0;
    else if (clear_i) phase_o <= 1'b0;
    else if (step_i)  phase_o <= ~phase_o;
  end
endmodule

// File: rtl/tpg_mux.sv
module tpg_mux
  import adc_tpg_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  tpg_mode_e         mode_i,
  input  logic              phase_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] pn9_i,
  input  logic [DATA_W-1:0] pn23_i,
  output logic [DATA_W-1:0] word_o
);
  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W-1);
  localparam logic [DATA_W-1:0] PFS = '1;
  localparam logic [DATA_W-1:0] NFS = '0;

  logic [DATA_W-1:0] check_a;

  // odd bits set: 0x2AAA for 14 bits
  for (genvar i = 0; i < DATA_W; i++) begin : g_chk
    assign check_a[i] = (i % 2) == 1;
  end

  always_comb begin
    unique case (mode_i)
      MODE_OFF:    word_o = data_i;
      MODE_MID:    word_o = MID;
      MODE_PFS:    word_o = PFS;
      MODE_NFS:    word_o = NFS;
      MODE_CHECK:  word_o = phase_i ? ~check_a : check_a;
      MODE_PN23:   word_o = pn23_i;
      MODE_PN9:    word_o = pn9_i;
      MODE_TOGGLE: word_o = phase_i ? NFS : PFS;
      default:     word_o = data_i;
    endcase
  end
endmodule

// File: rtl/adc_tpg.sv
module adc_tpg
  import adc_tpg_pkg::*;
#(
  parameter int DATA_W   = 14,
  parameter int PN9_W    = 9,
  parameter int PN9_TAP  = 5,
  parameter int PN23_W   = 23,
  parameter int PN23_TAP = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_en_i,
  input  logic [2:0]        mode_i,
  input  logic              pn23_rst_i,
  input  logic              pn9_rst_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  tpg_mode_e         mode;
  logic              phase;
  logic [DATA_W-1:0] pn9_word, pn23_word, next_word;

  assign mode = tpg_mode_e'(mode_i);

  tpg_lfsr #(.POLY_W(PN9_W), .TAP(PN9_TAP), .OUT_W(DATA_W)) i_pn9 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .seed_i (pn9_rst_i),
    .step_i (sample_en_i && mode == MODE_PN9),
    .word_o (pn9_word)
  );

  tpg_lfsr #(.POLY_W(PN23_W), .TAP(PN23_TAP), .OUT_W(DATA_W)) i_pn23 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .seed_i (pn23_rst_i),
    .step_i (sample_en_i && mode == MODE_PN23),
    .word_o (pn23_word)
  );

  tpg_phase i_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (!(mode == MODE_CHECK || mode == MODE_TOGGLE)),
    .step_i  (sample_en_i),
    .phase_o (phase)
  );

  tpg_mux #(.DATA_W(DATA_W)) i_mux (
    .mode_i  (mode),
    .phase_i (phase),
    .data_i  (data_i),
    .pn9_i   (pn9_word),
    .pn23_i  (pn23_word),
    .word_o  (next_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          data_o <= '0;
    else if (sample_en_i) data_o <= next_word;
  end
endmodule

// File: rtl/adc_tpg_chk.sv
module adc_tpg_chk #(
  parameter int DATA_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sample_en_i,
  input logic [2:0]        mode_i,
  input logic              pn23_rst_i,
  input logic              pn9_rst_i,
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W-1:0] data_o
);
  logic tog_q, rst9_q, rst23_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q   <= 1'b0;
      rst9_q  <= 1'b0;
      rst23_q <= 1'b0;
    end else begin
      rst9_q  <= pn9_rst_i;
      rst23_q <= pn23_rst_i;
      if (mode_i != 3'd7)   tog_q <= 1'b0;
      else if (sample_en_i) tog_q <= 1'b1;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_en_i |=> $stable(data_o)); // R10
  AST_PASS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_en_i && mode_i == 3'd0) |=> data_o == $past(data_i)); // R2
  AST_MIDSCALE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_en_i && mode_i == 3'd1) |=> data_o == 14'h2000); // R3
  AST_POS_FS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_en_i && mode_i == 3'd2) |=> data_o == 14'h3FFF); // R3
  AST_NEG_FS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_en_i && mode_i == 3'd3) |=> data_o == 14'h0000); // R3
  AST_TOGGLE_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_en_i && mode_i == 3'd7 && tog_q) |=> data_o == ~$past(data_o)); // R5
  AST_PN9_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst9_q && sample_en_i && mode_i == 3'd6) |=> data_o == 14'h3FFF); // R8
  AST_PN23_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst23_q && sample_en_i && mode_i == 3'd5) |=> data_o == 14'h3FFF); // R8
endmodule

bind adc_tpg adc_tpg_chk #(.DATA_W(DATA_W)) i_adc_tpg_chk (.*);

// File: tb/test_adc_tpg.sv
`timescale 1ns/1ps
module test_adc_tpg;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sample_en_i = 1'b0;
  logic [2:0]  mode_i = 3'd0;
  logic        pn23_rst_i = 1'b0;
  logic        pn9_rst_i = 1'b0;
  logic [13:0] data_i = '0;
  logic [13:0] data_o;

  int checks = 0;
  int failures = 0;

  logic [13:0] m_out = '0;
  logic [13:0] m_h9  = '1;
  logic [22:0] m_s23 = '1;
  logic        m_ph  = 1'b0;

  always #4 clk_i = ~clk_i;

  adc_tpg i_adc_tpg (.*);

  task automatic check(input logic [13:0] exp, input string req);
    checks++;
    if (data_o !== exp) begin
      failures++;
      $display("FAIL %s: data_o=%h expected=%h mode=%0d t=%0t", req, data_o, exp, mode_i, $time);
    end
  endtask

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1, 3'd2, 3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R7";
      3'd6: return "R6";
      default: return "R5";
    endcase
  endfunction

  // one cycle: drive after negedge, update model, compare at next negedge
  task automatic cyc(input logic en, input logic [2:0] m, input logic r9, input logic r23,
                     input logic [13:0] d, input string req);
    logic [13:0] w;
    sample_en_i = en; mode_i = m; pn9_rst_i = r9; pn23_rst_i = r23; data_i = d;
    case (m)
      3'd0: w = d;
      3'd1: w = 14'h2000;
      3'd2: w = 14'h3FFF;
      3'd3: w = 14'h0000;
      3'd4: w = m_ph ? 14'h1555 : 14'h2AAA;
      3'd5: w = m_s23[22:9];
      3'd6: w = m_h9;
      default: w = m_ph ? 14'h0000 : 14'h3FFF;
    endcase
    if (en) m_out = w;
    if (r9) m_h9 = '1;
    else if (en && m == 3'd6) m_h9 = {m_h9[12:0], m_h9[8] ^ m_h9[4]};
    if (r23) m_s23 = '1;
    else if (en && m == 3'd5) m_s23 = {m_s23[21:0], m_s23[22] ^ m_s23[17]};
    if (!(m == 3'd4 || m == 3'd7)) m_ph = 1'b0;
    else if (en) m_ph = ~m_ph;
    @(negedge clk_i);
    check(m_out, req);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog: run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(14'h0000, "R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(14'h0000, "R1");

    // sweep all modes, enable every cycle then sparse enable
    for (int m = 0; m < 8; m++) begin
      for (int i = 0; i < 40; i++)
        cyc(1'b1, 3'(m), 1'b0, 1'b0, 14'(i * 397 + m * 1111), tag_of(3'(m)));
      for (int i = 0; i < 30; i++)
        cyc(i % 3 != 0, 3'(m), 1'b0, 1'b0, 14'(i * 53 + 7),
            (i % 3 != 0) ? tag_of(3'(m)) : "R10");
    end

    // long PN runs to cover many states
    for (int i = 0; i < 600; i++) cyc(1'b1, 3'd6, 1'b0, 1'b0, '0, "R6");
    for (int i = 0; i < 2000; i++) cyc(1'b1, 3'd5, 1'b0, 1'b0, '0, "R7");

    // reset held: output stays at seed word, then sequence restarts
    for (int i = 0; i < 5; i++) cyc(1'b1, 3'd6, 1'b1, 1'b0, '0, "R8");
    for (int i = 0; i < 20; i++) cyc(1'b1, 3'd6, 1'b0, 1'b0, '0, "R8");
    for (int i = 0; i < 5; i++) cyc(1'b1, 3'd5, 1'b0, 1'b1, '0, "R8");
    for (int i = 0; i < 20; i++) cyc(1'b1, 3'd5, 1'b0, 1'b0, '0, "R8");
    // reset asserted in another mode still reseeds
    for (int i = 0; i < 10; i++) cyc(1'b1, 3'd6, 1'b0, 1'b0, '0, "R6");
    cyc(1'b1, 3'd1, 1'b1, 1'b1, '0, "R8");
    for (int i = 0; i < 6; i++) cyc(1'b1, 3'd6, 1'b0, 1'b0, '0, "R8");

    // resume after detour; phase restart after leaving
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 7; i++) cyc(1'b1, 3'd5, 1'b0, 1'b0, '0, "R9");
      for (int i = 0; i < 5; i++) cyc(1'b1, 3'd6, 1'b0, 1'b0, '0, "R9");
      for (int i = 0; i < 3; i++) cyc(1'b1, 3'd4, 1'b0, 1'b0, '0, "R11");
      cyc(1'b1, 3'd0, 1'b0, 1'b0, 14'h0ABC, "R11");
      for (int i = 0; i < 3; i++) cyc(1'b1, 3'd7, 1'b0, 1'b0, '0, "R11");
      for (int i = 0; i < 2; i++) cyc(1'b1, 3'd4, 1'b0, 1'b0, '0, "R11");
      cyc(1'b0, 3'd2, 1'b0, 1'b0, '0, "R10");
      cyc(1'b1, 3'd4, 1'b0, 1'b0, '0, "R11");
    end

    // idle cycles in a generator mode do not advance it
    for (int i = 0; i < 4; i++) cyc(1'b0, 3'd5, 1'b0, 1'b0, 14'h1234, "R10");
    for (int i = 0; i < 4; i++) cyc(1'b1, 3'd5, 1'b0, 1'b0, '0, "R10");

    // asynchronous reset mid-run
    rst_ni = 1'b0;
    m_out = '0; m_h9 = '1; m_s23 = '1; m_ph = 1'b0;
    #1;
    check(14'h0000, "R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    cyc(1'b1, 3'd6, 1'b0, 1'b0, '0, "R1");
    cyc(1'b1, 3'd5, 1'b0, 1'b0, '0, "R1");
    cyc(1'b1, 3'd4, 1'b0, 1'b0, '0, "R1");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule